// File: doc/BRIEF.md
# Predicate Register File with Guarded Commit

This block holds the one-bit predicates of a small in-order datapath and decides, for each issued operation, whether its result may be written back. A compare takes two 64-bit operands and a condition code and writes two predicates at once: the first target receives the outcome and the second receives its inverse. Every later operation names one predicate. When that predicate reads as one, the operation's write-back enable is raised; when it reads as zero, the operation still passes through in order, but its result is dropped.

Used this way, an if/else becomes a compare followed by two guarded assignments that issue back to back, with no branch. Each arm tests one of the two complementary predicates, so exactly one arm commits. Two issue slots can test predicates in the same cycle. A compare result is forwarded to the issue logic, so an operation in the very next cycle already sees the new value.

Top module: `prf_guarded_commit`

## Requirements
- R1: The file holds 64 predicates, selected by a 6-bit index from 0 to 63; any index can be written by a compare and tested by either issue slot.
- R2: Predicate 0 always reads as 1; a compare naming 0 as either target leaves it at 1, and the other target is still written.
- R3: A legal compare writes the condition outcome to `cmp_tgt_t` and its complement to `cmp_tgt_f`.
- R4: Condition codes on `cmp_cond`: 0 = equal, 1 = not equal, 2 = signed less-than (a < b), 3 = unsigned less-than (a < b), over 64-bit operands.
- R5: For each slot k, `wb_en[k]` is high in the cycle after issue exactly when `iss_valid[k]` was 1 and the named predicate read 1; an issue under a zero predicate, or no issue, gives 0.
- R6: A predicate keeps its value until a later compare overwrites it, so any number of later operations test the same value.
- R7: A compare whose two targets are equal writes nothing, and `cmp_illegal` is high in the following cycle; otherwise `cmp_illegal` is 0.
- R8: An issue in the cycle after a compare sees that compare's result; an issue in the same cycle as the compare sees the previous value.
- R9: Synchronous active-high reset clears predicates 1 to 63, and `wb_en` and `cmp_illegal` read 0 after it.
- R10: The two arms of an if/else, guarded by the two targets of one compare and issued in consecutive cycles, result in exactly one raised write-back enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_cond | input | 2 | Condition code (see R4) |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| cmp_tgt_t | input | 6 | Target receiving the outcome |
| cmp_tgt_f | input | 6 | Target receiving the complement |
| iss_valid | input | 2 | Operation issued in slot 1 and slot 0 |
| iss_pidx | input | 12 | Predicate index per slot, slot 0 in bits 5:0 |
| wb_en | output | 2 | Registered write-back enable per slot |
| cmp_illegal | output | 1 | Previous cycle's compare had equal targets |

## Verification
The bench aims at the forwarding edge: an issue right after a compare must see the new value, and one issued alongside it must see the old one; a design without the bypass, or with it on the wrong cycle, raises the enable of the wrong arm. Compares that aim at predicate 0 must leave it reading one, while still writing the other target; a design that stores into it would suppress every unconditional write-back. Equal targets must change nothing, so a design that lets one write win leaves a stale predicate, which is caught by later reads. Signed against unsigned ordering is probed with operands whose top bits differ, where a design with the codes swapped returns inverted outcomes.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    COND_EQ  = 2'd0,
    COND_NE  = 2'd1,
    COND_SLT = 2'd2,
    COND_ULT = 2'd3
  } cond_e;
endpackage

// File: rtl/prf_cmp_unit.sv
module prf_cmp_unit #(
  parameter int DW = 64
) (
  input  logic [1:0]    cond,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          outcome
);
  import prf_pkg::*;
  cond_e c;
  always_comb begin
    c = cond_e'(cond);
    unique case (c)
      COND_EQ:  outcome = (a == b);
      COND_NE:  outcome = (a != b);
      COND_SLT: outcome = ($signed(a) < $signed(b));
      default:  outcome = (a < b);
    endcase
  end
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int NP = 64,
  parameter int NR = 2,
  localparam int IW = $clog2(NP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      wa_t,
  input  logic [IW-1:0]      wa_f,
  input  logic               wd,
  input  logic [NR*IW-1:0]   ra,
  output logic [NR-1:0]      rd
);
  logic [NP-1:0] q;

  // Bit 0 is loaded with 1 on reset and never written afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {{(NP-1){1'b0}}, 1'b1};
    end else if (we) begin
      if (wa_t != '0) q[wa_t] <= wd;
      if (wa_f != '0) q[wa_f] <= ~wd;
    end
  end

  for (genvar k = 0; k < NR; k++) begin : g_rd
    assign rd[k] = q[ra[k*IW +: IW]];
  end

  assert_pair_complement_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wa_t != '0 && wa_f != '0 && wa_t != wa_f) |=> (q[$past(wa_t)] != q[$past(wa_f)]));
  assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
  assert_zero_entry_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> q[0]);
endmodule

// File: rtl/prf_issue_gate.sv
module prf_issue_gate #(
  parameter int NP = 64,
  localparam int IW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [IW-1:0] pidx,
  input  logic          bank_val,
  input  logic          byp_en,
  input  logic [IW-1:0] byp_t,
  input  logic [IW-1:0] byp_f,
  input  logic          byp_res,
  output logic          wb
);
  logic pred;

  always_comb begin
    pred = bank_val;
    if (pidx == '0)                   pred = 1'b1;
    else if (byp_en && pidx == byp_t) pred = byp_res;
    else if (byp_en && pidx == byp_f) pred = ~byp_res;
  end

  always_ff @(posedge clk) begin
    if (rst) wb <= 1'b0;
    else     wb <= valid & pred;
  end

  assert_discard_off_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !pred) |=> !wb);
  assert_always_true_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && pidx == '0) |=> wb);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !wb);
endmodule

// File: rtl/prf_guarded_commit.sv
module prf_guarded_commit #(
  parameter int NP = 64,
  parameter int DW = 64,
  parameter int NS = 2,
  localparam int IW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic [1:0]       cmp_cond,
  input  logic [DW-1:0]    cmp_a,
  input  logic [DW-1:0]    cmp_b,
  input  logic [IW-1:0]    cmp_tgt_t,
  input  logic [IW-1:0]    cmp_tgt_f,
  input  logic [NS-1:0]    iss_valid,
  input  logic [NS*IW-1:0] iss_pidx,
  output logic [NS-1:0]    wb_en,
  output logic             cmp_illegal
);
  logic          outcome;
  logic          st_vld, st_ill, st_res;
  logic [IW-1:0] st_t, st_f;
  logic          bank_we;
  logic [NS-1:0] bank_rd;

  prf_cmp_unit #(.DW(DW)) u_cmp (
    .cond(cmp_cond), .a(cmp_a), .b(cmp_b), .outcome(outcome)
  );

  // Result stage: holds the compare for one cycle, feeds bank and bypass.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld <= 1'b0;
      st_ill <= 1'b0;
      st_res <= 1'b0;
      st_t   <= '0;
      st_f   <= '0;
    end else begin
      st_vld <= cmp_valid;
      st_ill <= cmp_valid && (cmp_tgt_t == cmp_tgt_f);
      st_res <= outcome;
      st_t   <= cmp_tgt_t;
      st_f   <= cmp_tgt_f;
    end
  end

  assign bank_we     = st_vld & ~st_ill;
  assign cmp_illegal = st_ill;

  prf_bank #(.NP(NP), .NR(NS)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .wa_t(st_t), .wa_f(st_f),
    .wd(st_res), .ra(iss_pidx), .rd(bank_rd)
  );

  for (genvar k = 0; k < NS; k++) begin : g_slot
    prf_issue_gate #(.NP(NP)) u_gate (
      .clk(clk), .rst(rst), .valid(iss_valid[k]), .pidx(iss_pidx[k*IW +: IW]),
      .bank_val(bank_rd[k]), .byp_en(bank_we), .byp_t(st_t), .byp_f(st_f),
      .byp_res(st_res), .wb(wb_en[k])
    );
  end

  assert_same_target_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_tgt_t == cmp_tgt_f) |=> (cmp_illegal && !bank_we));
  assert_legal_not_flagged_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_tgt_t != cmp_tgt_f) |=> !cmp_illegal);
endmodule

// File: tb/prf_guarded_commit_tb.sv
module prf_guarded_commit_tb;
  localparam int IW = 6;
  logic clk = 1'b0;
  logic rst;
  logic cmp_valid;
  logic [1:0] cmp_cond;
  logic [63:0] cmp_a, cmp_b;
  logic [IW-1:0] cmp_tgt_t, cmp_tgt_f;
  logic [1:0] iss_valid;
  logic [2*IW-1:0] iss_pidx;
  logic [1:0] wb_en;
  logic cmp_illegal;

  int checks = 0;
  int fails = 0;
  bit model[64];
  bit exp_wb0, exp_wb1, exp_ill;

  always #4 clk = ~clk;

  prf_guarded_commit u_dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_tgt_t(cmp_tgt_t), .cmp_tgt_f(cmp_tgt_f),
    .iss_valid(iss_valid), .iss_pidx(iss_pidx), .wb_en(wb_en), .cmp_illegal(cmp_illegal)
  );

  function automatic bit cond_eval(input logic [1:0] c, input logic [63:0] a, input logic [63:0] b);
    case (c)
      2'd0: return a == b;
      2'd1: return a != b;
      2'd2: return $signed(a) < $signed(b);
      default: return a < b;
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cycle(input string req, input bit cv, input logic [1:0] cc,
                       input logic [63:0] a, input logic [63:0] b,
                       input int t, input int f,
                       input bit v0, input int p0, input bit v1, input int p1);
    cmp_valid = cv; cmp_cond = cc; cmp_a = a; cmp_b = b;
    cmp_tgt_t = IW'(t); cmp_tgt_f = IW'(f);
    iss_valid = {v1, v0}; iss_pidx = {IW'(p1), IW'(p0)};
    @(posedge clk);
    // Issues see every earlier compare, including the one just before.
    exp_wb0 = v0 && model[p0];
    exp_wb1 = v1 && model[p1];
    exp_ill = cv && (t == f);
    if (cv && t != f) begin
      bit r = cond_eval(cc, a, b);
      if (t != 0) model[t] = r;
      if (f != 0) model[f] = !r;
    end
    @(negedge clk);
    check(req, wb_en[0], exp_wb0, "wb_en[0]");
    check(req, wb_en[1], exp_wb1, "wb_en[1]");
    check(req, cmp_illegal, exp_ill, "cmp_illegal");
  endtask

  task automatic issue(input string req, input int p0, input int p1);
    cycle(req, 0, 2'd0, 64'd0, 64'd0, 0, 0, 1, p0, 1, p1);
  endtask

  task automatic compare(input string req, input logic [1:0] cc, input logic [63:0] a,
                         input logic [63:0] b, input int t, input int f);
    cycle(req, 1, cc, a, b, t, f, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    rst = 1'b1; cmp_valid = 0; cmp_cond = 0; cmp_a = 0; cmp_b = 0;
    cmp_tgt_t = 0; cmp_tgt_f = 0; iss_valid = 0; iss_pidx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", wb_en[0], 1'b0, "wb_en[0] in reset");
    check("R9", cmp_illegal, 1'b0, "cmp_illegal in reset");
    rst = 1'b0;

    // R9 / R2: cleared state, predicate 0 is one
    issue("R9", 5, 63);
    issue("R2", 0, 1);

    // R4 / R3: each condition code, targets spread across the file (R1)
    compare("R4", 2'd0, 64'd7, 64'd7, 1, 2);
    issue("R3", 1, 2);
    compare("R4", 2'd1, 64'd7, 64'd7, 3, 4);
    issue("R3", 3, 4);
    compare("R4", 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 10, 11);
    issue("R4", 10, 11);
    compare("R4", 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12, 13);
    issue("R4", 12, 13);
    compare("R1", 2'd3, 64'd1, 64'd2, 63, 62);
    issue("R1", 63, 62);

    // R8: same-cycle issue sees old value, next-cycle issue sees new
    cycle("R8", 1, 2'd0, 64'd1, 64'd2, 1, 2, 1, 1, 1, 2);
    issue("R8", 1, 2);

    // R2: compare targeting 0 leaves it one, other target still written
    compare("R2", 2'd0, 64'd3, 64'd3, 20, 0);
    issue("R2", 0, 20);
    compare("R2", 2'd0, 64'd3, 64'd3, 0, 21);
    issue("R2", 0, 21);

    // R7: equal targets change nothing
    compare("R7", 2'd0, 64'd5, 64'd5, 12, 12);
    issue("R7", 12, 13);
    compare("R7", 2'd1, 64'd5, 64'd5, 1, 1);
    issue("R7", 1, 2);

    // R6: many later operations test the same predicate
    for (int i = 0; i < 6; i++) issue("R6", 10, 11);

    // R10 / R5: if (x == 4) z = 9 else z = 0, both arms back to back
    for (int x = 3; x <= 5; x++) begin
      int sum;
      compare("R10", 2'd0, 64'(x), 64'd4, 30, 31);
      cycle("R10", 0, 0, 0, 0, 0, 0, 1, 30, 0, 0);
      sum = wb_en[0];
      cycle("R5", 0, 0, 0, 0, 0, 0, 1, 31, 0, 0);
      sum += wb_en[0];
      check("R10", sum == 1, 1'b1, "exactly one arm committed");
    end

    // R5: no issue gives no enable even under a true predicate
    cycle("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 30);

    // R9: reset mid-run clears predicates again
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    issue("R9", 10, 62);
    issue("R9", 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule